// File: doc/BRIEF.md
# One-Hot Symbol Link Endpoint Pair

This block holds both ends of a point-to-point link that moves packets as 2-bit symbols. The transmit end takes words on a valid/ready interface and cuts each one into 2-bit symbols. It raises exactly one of four data wires for each symbol and waits for the far end to acknowledge. It then drops the wire and waits for the acknowledge to fall before it raises the next one. After the last word of a packet, it sends a symbol on a dedicated end-of-packet wire.

The receive end sees a symbol when one wire is raised, answers by raising its acknowledge, and lowers the acknowledge once every wire is back at zero. It rebuilds words from the symbols and presents each word as a one-cycle pulse. The last word of a packet carries a last flag.

The two ends share a clock and a reset but are wired only through the top module's link ports. A user connects them directly, or through any delay, or to a different partner. Throughput is one symbol for each full four-phase exchange.

Top module: `olink_pair`

## Requirements
- R1: While reset is held and after it is released, all link wires and the receive acknowledge are 0, `tx_ready_o` is 1, `rx_valid_o` is 0 and `rx_err_o` is 0.
- R2: Symbol value v (0..3) is sent by raising data wire v only: bit 0 of `lnk_tx_d_o` for value 0, up to bit 3 for value 3. At most one of the five forward wires (4 data plus end-of-packet) is high in any cycle.
- R3: Inside a word the pair in bits [1:0] goes first, then bits [3:2], and so on up to the top pair.
- R4: The transmitter keeps a raised symbol unchanged while the acknowledge is low. It drops all wires once it sees the acknowledge high. It raises no new symbol while the acknowledge stays high.
- R5: The receiver raises `lnk_rx_ack_o` after it sees exactly one forward wire high. It keeps the acknowledge high while the wire stays high, and lowers it after all forward wires are 0.
- R6: Words that cross the link come out on `rx_data_o` with a one-cycle `rx_valid_o`, in the order sent and equal to the words sent.
- R7: An accepted word with `tx_last_i`=1 is followed by an end-of-packet symbol. The receiver delivers that word with `rx_last_o`=1. Every other word is delivered with `rx_last_o`=0.
- R8: A receive state with two or more forward wires high sets `rx_err_o`. That state is not acknowledged, and the flag stays set until reset.
- R9: An end-of-packet symbol that arrives with no complete word waiting is acknowledged, sets `rx_err_o`, and produces no output pulse.
- R10: `tx_ready_o` is 0 from the cycle after a word is accepted until the exchange for that word, including any end-of-packet symbol, has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ends |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| tx_valid_i | input | 1 | A word is offered to the transmitter |
| tx_ready_o | output | 1 | The transmitter can accept a word |
| tx_data_i | input | WORD_W | Word to send |
| tx_last_i | input | 1 | The offered word ends its packet |
| lnk_tx_d_o | output | 4 | Transmit one-hot data wires |
| lnk_tx_eop_o | output | 1 | Transmit end-of-packet wire |
| lnk_tx_ack_i | input | 1 | Acknowledge seen by the transmitter |
| lnk_rx_d_i | input | 4 | One-hot data wires at the receiver |
| lnk_rx_eop_i | input | 1 | End-of-packet wire at the receiver |
| lnk_rx_ack_o | output | 1 | Acknowledge driven by the receiver |
| rx_valid_o | output | 1 | One-cycle pulse: a rebuilt word is present |
| rx_data_o | output | WORD_W | Rebuilt word |
| rx_last_o | output | 1 | The rebuilt word ends its packet |
| rx_err_o | output | 1 | Sticky protocol error flag |

## Verification
A table of packets runs through a loopback that delays both directions by a register. The words are all-zero, all-one, alternating-bit, single-bit and mixed. They are sent as single-word and multi-word packets, so every symbol value lands in every pair position, and a word with `rx_last_o` wrong or data out of order shows up.

With the loopback opened, the bench plays the far end of each side by hand. On the transmit side it reads the wire sequence of a known word to tell apart pair order and wire mapping. It holds the acknowledge low and then high to separate a held symbol from an early next symbol. On the receive side it drives a clash of two wires and a lone end-of-packet, which tell a legal symbol from a protocol error.

// File: rtl/olink_pkg.sv
package olink_pkg;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SYM  = 2'd1,
    TX_RTZ  = 2'd2
  } tx_phase_e;

  typedef enum logic {
    RX_OPEN = 1'b0,
    RX_HELD = 1'b1
  } rx_phase_e;

  localparam int unsigned LINK_WIRES = 4;

  function automatic logic [LINK_WIRES-1:0] sym_encode(input logic [1:0] v);
    logic [LINK_WIRES-1:0] w;
    w = '0;
    w[v] = 1'b1;
    return w;
  endfunction

  function automatic logic [1:0] sym_decode(input logic [LINK_WIRES-1:0] w);
    logic [1:0] v;
    v = 2'd0;
    for (int i = 0; i < LINK_WIRES; i++) begin
      if (w[i]) v = 2'(i);
    end
    return v;
  endfunction

endpackage

// File: rtl/olink_rst_sync.sv
module olink_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/olink_tx.sv
module olink_tx
  import olink_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  output logic [3:0]        d_o,
  output logic              eop_o,
  input  logic              ack_i
);
  localparam int unsigned SYMS  = WORD_W / 2;
  localparam int unsigned IDX_W = (SYMS > 1) ? $clog2(SYMS) : 1;
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(SYMS - 1);

  tx_phase_e          phase_q, phase_n;
  logic [WORD_W-1:0]  word_q, word_n;
  logic [IDX_W-1:0]   idx_q, idx_n;
  logic               last_q, last_n;
  logic               trail_q, trail_n;
  logic [3:0]         dw_q, dw_n;
  logic               ew_q, ew_n;
  logic [WORD_W-1:0]  shifted;
  logic               accept;

  assign in_ready = (phase_q == TX_IDLE) && !ack_i;
  assign accept   = in_valid && in_ready;
  assign shifted  = word_q >> {idx_q + IDX_W'(1), 1'b0};

  always_comb begin
    phase_n = phase_q;
    word_n  = word_q;
    idx_n   = idx_q;
    last_n  = last_q;
    trail_n = trail_q;
    dw_n    = dw_q;
    ew_n    = ew_q;
    unique case (phase_q)
      TX_IDLE: begin
        if (accept) begin
          word_n  = in_data;
          last_n  = in_last;
          idx_n   = '0;
          trail_n = 1'b0;
          dw_n    = sym_encode(in_data[1:0]);
          phase_n = TX_SYM;
        end
      end
      TX_SYM: begin
        if (ack_i) begin
          dw_n    = '0;
          ew_n    = 1'b0;
          phase_n = TX_RTZ;
        end
      end
      TX_RTZ: begin
        if (!ack_i) begin
          if (trail_q) begin
            trail_n = 1'b0;
            phase_n = TX_IDLE;
          end else if (idx_q == IDX_END) begin
            if (last_q) begin
              trail_n = 1'b1;
              ew_n    = 1'b1;
              phase_n = TX_SYM;
            end else begin
              phase_n = TX_IDLE;
            end
          end else begin
            idx_n   = idx_q + IDX_W'(1);
            dw_n    = sym_encode(shifted[1:0]);
            phase_n = TX_SYM;
          end
        end
      end
      default: phase_n = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= TX_IDLE;
      word_q  <= '0;
      idx_q   <= '0;
      last_q  <= 1'b0;
      trail_q <= 1'b0;
      dw_q    <= '0;
      ew_q    <= 1'b0;
    end else begin
      phase_q <= phase_n;
      word_q  <= word_n;
      idx_q   <= idx_n;
      last_q  <= last_n;
      trail_q <= trail_n;
      dw_q    <= dw_n;
      ew_q    <= ew_n;
    end
  end

  assign d_o   = dw_q;
  assign eop_o = ew_q;

  // R2: one forward wire at most
  a_r2_one_wire: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({d_o, eop_o}) <= 1);
  // R4: a raised symbol is held until acknowledged
  a_r4_hold_symbol: assert property (@(posedge clk) disable iff (!rst_n)
    (({d_o, eop_o} != 5'd0) && !ack_i) |=> $stable({d_o, eop_o}));
  // R4: nothing new is raised while ack is still high
  a_r4_no_early_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (({d_o, eop_o} == 5'd0) && ack_i) |=> ({d_o, eop_o} == 5'd0));
endmodule

// File: rtl/olink_rx_detect.sv
module olink_rx_detect
  import olink_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] d_i,
  input  logic       eop_i,
  output logic       ack_o,
  output logic       sym_stb,
  output logic       sym_eop,
  output logic [1:0] sym_val,
  output logic       clash_stb
);
  rx_phase_e  phase_q, phase_n;
  logic       stb_q, stb_n;
  logic       eop_q, eop_n;
  logic [1:0] val_q, val_n;
  logic       clash_q, clash_n;
  logic [2:0] raised;

  assign raised = 3'($countones({d_i, eop_i}));

  always_comb begin
    phase_n = phase_q;
    stb_n   = 1'b0;
    eop_n   = eop_q;
    val_n   = val_q;
    clash_n = 1'b0;
    unique case (phase_q)
      RX_OPEN: begin
        if (raised == 3'd1) begin
          stb_n   = 1'b1;
          eop_n   = eop_i;
          val_n   = sym_decode(d_i);
          phase_n = RX_HELD;
        end else if (raised > 3'd1) begin
          clash_n = 1'b1;
        end
      end
      RX_HELD: begin
        if (raised == 3'd0) phase_n = RX_OPEN;
      end
      default: phase_n = RX_OPEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= RX_OPEN;
      stb_q   <= 1'b0;
      eop_q   <= 1'b0;
      val_q   <= '0;
      clash_q <= 1'b0;
    end else begin
      phase_q <= phase_n;
      stb_q   <= stb_n;
      eop_q   <= eop_n;
      val_q   <= val_n;
      clash_q <= clash_n;
    end
  end

  assign ack_o     = (phase_q == RX_HELD);
  assign sym_stb   = stb_q;
  assign sym_eop   = eop_q;
  assign sym_val   = val_q;
  assign clash_stb = clash_q;

  // R8: a clash is never acknowledged
  a_r8_no_ack_on_clash: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_o && ($countones({d_i, eop_i}) > 1)) |=> !ack_o);
  // R5: ack falls once the spacer is seen
  a_r5_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && ({d_i, eop_i} == 5'd0)) |=> !ack_o);
  // R5: a symbol report comes with the acknowledge
  a_r5_stb_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    sym_stb |-> ack_o);
endmodule

// File: rtl/olink_rx_assemble.sv
module olink_rx_assemble #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_stb,
  input  logic              sym_eop,
  input  logic [1:0]        sym_val,
  input  logic              clash_stb,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output logic              err_o
);
  localparam int unsigned SYMS  = WORD_W / 2;
  localparam int unsigned CNT_W = (SYMS > 1) ? $clog2(SYMS) : 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(SYMS - 1);

  logic [WORD_W-1:0] acc_q, acc_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [WORD_W-1:0] pend_q, pend_n;
  logic              pend_v_q, pend_v_n;
  logic              ov_q, ov_n;
  logic [WORD_W-1:0] od_q, od_n;
  logic              ol_q, ol_n;
  logic              err_q, err_n;
  logic [WORD_W-1:0] shifted_in;

  assign shifted_in = {sym_val, acc_q[WORD_W-1:2]};

  always_comb begin
    acc_n    = acc_q;
    cnt_n    = cnt_q;
    pend_n   = pend_q;
    pend_v_n = pend_v_q;
    ov_n     = 1'b0;
    od_n     = od_q;
    ol_n     = ol_q;
    err_n    = err_q | clash_stb;
    if (sym_stb) begin
      if (sym_eop) begin
        if (pend_v_q && (cnt_q == '0)) begin
          ov_n = 1'b1;
          od_n = pend_q;
          ol_n = 1'b1;
        end else begin
          err_n = 1'b1;
        end
        pend_v_n = 1'b0;
        cnt_n    = '0;
      end else begin
        if (pend_v_q) begin
          ov_n     = 1'b1;
          od_n     = pend_q;
          ol_n     = 1'b0;
          pend_v_n = 1'b0;
        end
        acc_n = shifted_in;
        if (cnt_q == CNT_END) begin
          pend_n   = shifted_in;
          pend_v_n = 1'b1;
          cnt_n    = '0;
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      cnt_q    <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      ov_q     <= 1'b0;
      od_q     <= '0;
      ol_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      acc_q    <= acc_n;
      cnt_q    <= cnt_n;
      pend_q   <= pend_n;
      pend_v_q <= pend_v_n;
      ov_q     <= ov_n;
      od_q     <= od_n;
      ol_q     <= ol_n;
      err_q    <= err_n;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_last  = ol_q;
  assign err_o     = err_q;

  // R8: the error flag is sticky
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
  // R6: output is a single-cycle pulse
  a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R9: a lone end-of-packet raises the error
  a_r9_lone_eop: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && sym_eop && !pend_v_q) |=> (err_o && !out_valid));
endmodule

// File: rtl/olink_pair.sv
module olink_pair #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_last_i,
  output logic [3:0]        lnk_tx_d_o,
  output logic              lnk_tx_eop_o,
  input  logic              lnk_tx_ack_i,
  input  logic [3:0]        lnk_rx_d_i,
  input  logic              lnk_rx_eop_i,
  output logic              lnk_rx_ack_o,
  output logic              rx_valid_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_last_o,
  output logic              rx_err_o
);
  logic       rst_n_s;
  logic       sym_stb;
  logic       sym_eop;
  logic [1:0] sym_val;
  logic       clash_stb;

  olink_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  olink_tx #(.WORD_W(WORD_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .in_valid (tx_valid_i),
    .in_ready (tx_ready_o),
    .in_data  (tx_data_i),
    .in_last  (tx_last_i),
    .d_o      (lnk_tx_d_o),
    .eop_o    (lnk_tx_eop_o),
    .ack_i    (lnk_tx_ack_i)
  );

  olink_rx_detect u_det (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .d_i       (lnk_rx_d_i),
    .eop_i     (lnk_rx_eop_i),
    .ack_o     (lnk_rx_ack_o),
    .sym_stb   (sym_stb),
    .sym_eop   (sym_eop),
    .sym_val   (sym_val),
    .clash_stb (clash_stb)
  );

  olink_rx_assemble #(.WORD_W(WORD_W)) u_asm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .sym_stb   (sym_stb),
    .sym_eop   (sym_eop),
    .sym_val   (sym_val),
    .clash_stb (clash_stb),
    .out_valid (rx_valid_o),
    .out_data  (rx_data_o),
    .out_last  (rx_last_o),
    .err_o     (rx_err_o)
  );
endmodule

// File: tb/sim_olink_pair.sv
module sim_olink_pair;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 8;
  localparam int N_VEC      = 11;
  localparam int WATCHDOG   = 150000;
  // {last, data}
  localparam logic [8:0] VEC [N_VEC] = '{
    {1'b0, 8'h00}, {1'b0, 8'hFF}, {1'b1, 8'h55},
    {1'b1, 8'hAA},
    {1'b0, 8'h1E}, {1'b0, 8'hE1}, {1'b0, 8'h80}, {1'b1, 8'h01},
    {1'b1, 8'h3C},
    {1'b0, 8'hC3}, {1'b1, 8'h7E}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_valid = 1'b0;
  logic tx_ready;
  logic [WORD_W-1:0] tx_data = '0;
  logic tx_last = 1'b0;
  logic [3:0] tx_d;
  logic tx_eop;
  logic tx_ack;
  logic [3:0] rx_d;
  logic rx_eop;
  logic rx_ack;
  logic rx_valid;
  logic [WORD_W-1:0] rx_data;
  logic rx_last;
  logic rx_err;

  logic loop_on = 1'b0;
  logic [3:0] fwd_d_q = '0;
  logic fwd_e_q = 1'b0;
  logic back_q = 1'b0;
  logic [3:0] bd = '0;
  logic be = 1'b0;
  logic ba = 1'b0;

  int checks = 0;
  int fails = 0;
  int got = 0;
  int stray = 0;
  int cyc = 0;
  logic [3:0] seen [5];

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    fwd_d_q <= tx_d;
    fwd_e_q <= tx_eop;
    back_q  <= rx_ack;
  end

  assign rx_d   = loop_on ? fwd_d_q : bd;
  assign rx_eop = loop_on ? fwd_e_q : be;
  assign tx_ack = loop_on ? back_q  : ba;

  olink_pair #(.WORD_W(WORD_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_data_i(tx_data), .tx_last_i(tx_last),
    .lnk_tx_d_o(tx_d), .lnk_tx_eop_o(tx_eop), .lnk_tx_ack_i(tx_ack),
    .lnk_rx_d_i(rx_d), .lnk_rx_eop_i(rx_eop), .lnk_rx_ack_o(rx_ack),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data), .rx_last_o(rx_last), .rx_err_o(rx_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      summary();
      $finish;
    end
  end

  // R6 R7: output monitor against the vector table
  always @(negedge clk) begin
    if (rx_valid) begin
      if (loop_on && got < N_VEC) begin
        chk(rx_data == VEC[got][7:0], "R6 word", int'(rx_data), int'(VEC[got][7:0]));
        chk(rx_last == VEC[got][8], "R7 last", int'(rx_last), int'(VEC[got][8]));
        got++;
      end else begin
        stray++;
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    loop_on = 1'b0;
    bd = '0; be = 1'b0; ba = 1'b0;
    tx_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic l);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = d; tx_last = l;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // plays the far receiver for one symbol; returns the forward wires seen
  task automatic take_symbol(output logic [4:0] w);
    int n = 0;
    while ({tx_d, tx_eop} == 5'd0 && n < 100) begin @(negedge clk); n++; end
    w = {tx_d, tx_eop};
    ba = 1'b1;
    n = 0;
    while ({tx_d, tx_eop} != 5'd0 && n < 100) begin @(negedge clk); n++; end
    ba = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [4:0] w;
    int n;
    int stray0;

    // R1: state under reset and after release
    @(negedge clk);
    chk({tx_d, tx_eop, rx_ack} == 6'd0, "R1 wires in reset", int'({tx_d, tx_eop, rx_ack}), 0);
    do_reset();
    chk({tx_d, tx_eop, rx_ack} == 6'd0, "R1 wires", int'({tx_d, tx_eop, rx_ack}), 0);
    chk(tx_ready == 1'b1, "R1 ready", int'(tx_ready), 1);
    chk(rx_valid == 1'b0 && rx_err == 1'b0, "R1 rx idle", int'({rx_valid, rx_err}), 0);

    // R6 R7: table of packets through the delayed loopback
    loop_on = 1'b1;
    for (int i = 0; i < N_VEC; i++) send(VEC[i][7:0], VEC[i][8]);
    n = 0;
    while (got < N_VEC && n < 5000) begin @(negedge clk); n++; end
    chk(got == N_VEC, "R6 word count", got, N_VEC);
    chk(stray == 0, "R6 no extra words", stray, 0);
    chk(rx_err == 1'b0, "R8 no error on clean link", int'(rx_err), 0);
    repeat (10) @(negedge clk);

    // R2 R3 R7 R10: wire sequence of 0xB4 with last, far end by hand
    do_reset();
    send(8'hB4, 1'b1);
    chk(tx_ready == 1'b0, "R10 ready low in flight", int'(tx_ready), 0);
    for (int k = 0; k < 5; k++) begin
      take_symbol(w);
      seen[k] = w[4:1];
      if (k == 4) chk(w == 5'b00001, "R7 eop symbol", int'(w), 1);
      else        chk(w[0] == 1'b0, "R2 eop low on data", int'(w[0]), 0);
    end
    chk(seen[0] == 4'b0001, "R3 pair0 value0 wire0", int'(seen[0]), 1);
    chk(seen[1] == 4'b0010, "R3 pair1 value1 wire1", int'(seen[1]), 2);
    chk(seen[2] == 4'b1000, "R2 value3 wire3", int'(seen[2]), 8);
    chk(seen[3] == 4'b0100, "R3 pair3 value2 wire2", int'(seen[3]), 4);
    chk(tx_ready == 1'b1, "R10 ready back", int'(tx_ready), 1);

    // R4: hold while ack low, drop on ack, nothing new while ack high
    send(8'h03, 1'b0);
    repeat (2) @(negedge clk);
    w = {tx_d, tx_eop};
    repeat (10) @(negedge clk);
    chk({tx_d, tx_eop} == w && w == 5'b10000, "R4 held until ack", int'({tx_d, tx_eop}), int'(w));
    ba = 1'b1;
    @(negedge clk);
    chk({tx_d, tx_eop} == 5'd0, "R4 drop on ack", int'({tx_d, tx_eop}), 0);
    repeat (10) @(negedge clk);
    chk({tx_d, tx_eop} == 5'd0, "R4 no raise while ack high", int'({tx_d, tx_eop}), 0);
    ba = 1'b0;
    repeat (2) @(negedge clk);
    chk(tx_d == 4'b0001, "R4 next after ack low", int'(tx_d), 1);

    // R5: receiver acknowledge sequence
    do_reset();
    bd = 4'b0100;
    repeat (2) @(negedge clk);
    chk(rx_ack == 1'b1, "R5 ack rises", int'(rx_ack), 1);
    repeat (5) @(negedge clk);
    chk(rx_ack == 1'b1, "R5 ack held", int'(rx_ack), 1);
    bd = 4'b0000;
    repeat (2) @(negedge clk);
    chk(rx_ack == 1'b0, "R5 ack falls", int'(rx_ack), 0);

    // R9: lone end-of-packet
    do_reset();
    stray0 = stray;
    be = 1'b1;
    repeat (3) @(negedge clk);
    chk(rx_ack == 1'b1, "R9 eop acked", int'(rx_ack), 1);
    be = 1'b0;
    repeat (3) @(negedge clk);
    chk(rx_err == 1'b1, "R9 error set", int'(rx_err), 1);
    chk(stray == stray0, "R9 no output", stray, stray0);

    // R8: clash of two wires
    do_reset();
    chk(rx_err == 1'b0, "R8 cleared by reset", int'(rx_err), 0);
    bd = 4'b0011;
    repeat (4) @(negedge clk);
    chk(rx_err == 1'b1, "R8 clash error", int'(rx_err), 1);
    chk(rx_ack == 1'b0, "R8 clash not acked", int'(rx_ack), 0);
    bd = 4'b0000;
    repeat (5) @(negedge clk);
    chk(rx_err == 1'b1, "R8 error sticky", int'(rx_err), 1);

    summary();
    $finish;
  end
endmodule